// File: doc/BRIEF.md
# Oversampled Serial Character Receiver with Break Recovery

This block turns an asynchronous serial line into parallel characters. A sample enable from outside pulses at sixteen times the bit rate. The receiver first passes the line through a two-flop synchroniser. It confirms each start bit at its middle, then samples the data bits, an optional parity bit and the stop bit at their centres. For each character it delivers a one-cycle strobe with the data and three status flags: parity error, framing error and break.

Two recovery behaviours shape the design. If the stop bit is sampled low, the character is reported with a framing error. That low level is then treated as the start bit of the next character, which lets the receiver lock back onto a stream that is arriving back to back. If every sample of a character is low, the line is in break. The block then reports a single zero character marked as a break. It accepts nothing more until the line has been seen high on two consecutive samples and a new start bit follows. Character length, parity enable and parity sense are captured when each character starts.

Top module: `uart_rx_resync`

## Requirements
- R1: After reset, `rx_valid` is low and `rx_data` and all three flags are 0.
- R2: A start bit is confirmed by a second sample 8 ticks after the falling edge is seen. If the line is high at that sample, no character is produced and the receiver waits for a new falling edge.
- R3: Data bits are sampled every 16 ticks, starting 16 ticks after the start-bit confirmation, and placed least significant bit first. `rx_valid` is high for exactly one clock per character.
- R4: `cfg_len` selects 5 + `cfg_len` data bits (0 gives 5 bits, 3 gives 8). Bits of `rx_data` above the selected length are 0.
- R5: When `cfg_par_en` is 1, a parity bit follows the data. With `cfg_par_odd` = 0 the data and parity bits together must hold an even number of ones, and with 1 an odd number. A mismatch sets `rx_perr`. With parity disabled, `rx_perr` is 0.
- R6: A stop bit sampled low on a character that is not a break sets `rx_ferr`. `rx_ferr` and `rx_brk` are never set together.
- R7: After a framing error, the low stop bit is taken as the next start bit. It is sampled once more one tick later and, if still low, the next data bit is sampled 16 ticks after the stop-bit sample, with no new falling edge needed.
- R8: When the start, data, parity (if enabled) and stop samples are all low, exactly one character is produced, with `rx_data` = 0, `rx_brk` = 1, `rx_ferr` = 0 and `rx_perr` = 0, however long the line stays low.
- R9: After a break, no character is produced until the line has been sampled high on 2 consecutive ticks and a valid start bit has then arrived. A single high sample does not release the lock.
- R10: An all-zero data character with a high stop bit is an ordinary character, with `rx_brk` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_tick | input | 1 | One-cycle enable at 16x the bit rate |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| cfg_len | input | 2 | Data length select: number of bits minus 5 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rx_valid | output | 1 | One-cycle character strobe |
| rx_data | output | 8 | Received character, LSB-aligned |
| rx_perr | output | 1 | Parity mismatch for this character |
| rx_ferr | output | 1 | Stop bit sampled low |
| rx_brk | output | 1 | Character is a break |

## Verification
The main function is driven with an asymmetric 8-bit byte, a 5-bit character carrying extra high bits, and an all-zero byte with a good stop. Together these catch bit-order mistakes, wrong length masking, and a break being confused with an ordinary zero. Parity is tried with a correct even bit, a wrong even bit and a correct odd bit, which separates the parity sense from the presence of parity. A short low glitch tests start confirmation. A low stop bit followed at once by the data of a second character tests resynchronisation. A long low line, then a one-sample high blip, then a proper idle period tests the single break character and the two-sample release rule.

// File: rtl/uart_rx_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the oversampled serial receiver.
// Assumes a power-of-two oversampling ratio.
package uart_rx_pkg;
    localparam int OSR     = 16;  // ticks per bit
    localparam int MIN_LEN = 5;   // shortest character length

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_RESYNC,
        ST_BRKWAIT
    } rx_state_e;
endpackage

// File: rtl/rx_sync2.sv
`timescale 1ns/1ps
// Two-flop synchroniser for the asynchronous serial line.
// Assumes the line idles high, so the reset value is 1.
module rx_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic d_sync
);
    logic meta_q;
    logic sync_q;

    // Shift the raw line through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
        end else begin
            meta_q <= d_async;
            sync_q <= meta_q;
        end
    end

    assign d_sync = sync_q;
endmodule

// File: rtl/rx_parity_chk.sv
`timescale 1ns/1ps
// Parity check over a captured character.
// Assumes unused upper data bits are already 0.
module rx_parity_chk #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] data,
    input  logic          pbit,
    input  logic          odd,
    output logic          perr
);
    // The xor of data and parity must equal the parity sense.
    always_comb perr = (^data) ^ pbit ^ odd;
endmodule

// File: rtl/rx_frame_core.sv
`timescale 1ns/1ps
// Character framing state machine: start confirmation, data and parity
// capture, stop check, framing resynchronisation and break lock.
// Assumes rx is already synchronised and tick is a single-cycle enable.
module rx_frame_core
    import uart_rx_pkg::*;
#(
    parameter int DW  = 8,
    parameter int LW  = 2,
    parameter int REL = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          rx,
    input  logic [LW-1:0] cfg_len,
    input  logic          cfg_par_en,
    input  logic          cfg_par_odd,
    input  logic          perr_calc,
    output logic [DW-1:0] cap_data,
    output logic          cap_pbit,
    output logic          cap_odd,
    output logic          valid_o,
    output logic [DW-1:0] data_o,
    output logic          perr_o,
    output logic          ferr_o,
    output logic          brk_o
);
    localparam int CW  = $clog2(OSR);
    localparam int IW  = $clog2(DW);
    localparam int HW  = $clog2(REL + 1);
    localparam int MID = OSR / 2 - 1;

    rx_state_e     state_q;
    logic [CW-1:0] cnt_q;
    logic [IW-1:0] idx_q;
    logic [DW-1:0] data_q;
    logic          pbit_q;
    logic          zero_q;
    logic [HW-1:0] hi_q;
    logic [LW-1:0] len_q;
    logic          pen_q;
    logic          podd_q;
    logic          valid_q;
    logic [DW-1:0] dout_q;
    logic          perr_q;
    logic          ferr_q;
    logic          brk_q;
    logic [IW-1:0] last_idx;
    logic          bit_end;

    // Index of the final data bit for the captured length.
    always_comb last_idx = IW'(MIN_LEN - 1) + IW'(len_q);
    // Centre of a data, parity or stop bit.
    always_comb bit_end = (cnt_q == CW'(OSR - 1));

    // Framing sequencer and output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            data_q  <= '0;
            pbit_q  <= 1'b0;
            zero_q  <= 1'b1;
            hi_q    <= '0;
            len_q   <= '0;
            pen_q   <= 1'b0;
            podd_q  <= 1'b0;
            valid_q <= 1'b0;
            dout_q  <= '0;
            perr_q  <= 1'b0;
            ferr_q  <= 1'b0;
            brk_q   <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (tick) begin
                unique case (state_q)
                    ST_IDLE: begin
                        if (!rx) begin
                            state_q <= ST_START;
                            cnt_q   <= '0;
                        end
                    end
                    ST_START: begin
                        if (cnt_q == CW'(MID)) begin
                            if (rx) begin
                                state_q <= ST_IDLE;
                            end else begin
                                state_q <= ST_DATA;
                                cnt_q   <= '0;
                                idx_q   <= '0;
                                data_q  <= '0;
                                pbit_q  <= 1'b0;
                                zero_q  <= 1'b1;
                                len_q   <= cfg_len;
                                pen_q   <= cfg_par_en;
                                podd_q  <= cfg_par_odd;
                            end
                        end else begin
                            cnt_q <= cnt_q + CW'(1);
                        end
                    end
                    ST_DATA: begin
                        if (bit_end) begin
                            cnt_q         <= '0;
                            data_q[idx_q] <= rx;
                            if (rx) zero_q <= 1'b0;
                            if (idx_q == last_idx) state_q <= pen_q ? ST_PAR : ST_STOP;
                            else                   idx_q   <= idx_q + IW'(1);
                        end else begin
                            cnt_q <= cnt_q + CW'(1);
                        end
                    end
                    ST_PAR: begin
                        if (bit_end) begin
                            cnt_q   <= '0;
                            pbit_q  <= rx;
                            if (rx) zero_q <= 1'b0;
                            state_q <= ST_STOP;
                        end else begin
                            cnt_q <= cnt_q + CW'(1);
                        end
                    end
                    ST_STOP: begin
                        if (bit_end) begin
                            cnt_q   <= '0;
                            valid_q <= 1'b1;
                            if (rx) begin
                                dout_q  <= data_q;
                                perr_q  <= pen_q & perr_calc;
                                ferr_q  <= 1'b0;
                                brk_q   <= 1'b0;
                                state_q <= ST_IDLE;
                            end else if (zero_q) begin
                                dout_q  <= '0;
                                perr_q  <= 1'b0;
                                ferr_q  <= 1'b0;
                                brk_q   <= 1'b1;
                                hi_q    <= '0;
                                state_q <= ST_BRKWAIT;
                            end else begin
                                dout_q  <= data_q;
                                perr_q  <= pen_q & perr_calc;
                                ferr_q  <= 1'b1;
                                brk_q   <= 1'b0;
                                state_q <= ST_RESYNC;
                            end
                        end else begin
                            cnt_q <= cnt_q + CW'(1);
                        end
                    end
                    ST_RESYNC: begin
                        if (!rx) begin
                            state_q <= ST_DATA;
                            cnt_q   <= CW'(1);
                            idx_q   <= '0;
                            data_q  <= '0;
                            pbit_q  <= 1'b0;
                            zero_q  <= 1'b1;
                            len_q   <= cfg_len;
                            pen_q   <= cfg_par_en;
                            podd_q  <= cfg_par_odd;
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end
                    ST_BRKWAIT: begin
                        if (rx) begin
                            if (hi_q == HW'(REL - 1)) state_q <= ST_IDLE;
                            else                      hi_q    <= hi_q + HW'(1);
                        end else begin
                            hi_q <= '0;
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign cap_data = data_q;
    assign cap_pbit = pbit_q;
    assign cap_odd  = podd_q;
    assign valid_o  = valid_q;
    assign data_o   = dout_q;
    assign perr_o   = perr_q;
    assign ferr_o   = ferr_q;
    assign brk_o    = brk_q;

    // R3: the character strobe never lasts two clocks.
    assert_strobe_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> !valid_q);
    // R8: a break character carries zero data.
    assert_break_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && brk_q) |-> (dout_q == '0));
    // R6: framing error and break are exclusive.
    assert_ferr_brk_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> !(ferr_q && brk_q));
    // R4: the shortest length leaves the upper data bits clear.
    assert_upper_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && len_q == '0) |-> (dout_q[DW-1:MIN_LEN] == '0));
    // R9: while locked after a break, no character is issued.
    assert_break_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BRKWAIT) |=> !valid_q);
endmodule

// File: rtl/uart_rx_resync.sv
`timescale 1ns/1ps
// Serial character receiver top: synchroniser, framing core and parity check.
// Assumes sample_tick pulses at 16x the bit rate, one clock wide.
module uart_rx_resync #(
    parameter int DW  = 8,
    parameter int LW  = 2,
    parameter int REL = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sample_tick,
    input  logic          rx_line,
    input  logic [LW-1:0] cfg_len,
    input  logic          cfg_par_en,
    input  logic          cfg_par_odd,
    output logic          rx_valid,
    output logic [DW-1:0] rx_data,
    output logic          rx_perr,
    output logic          rx_ferr,
    output logic          rx_brk
);
    logic          rx_s;
    logic [DW-1:0] cap_data;
    logic          cap_pbit;
    logic          cap_odd;
    logic          perr_calc;

    rx_sync2 u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (rx_line),
        .d_sync  (rx_s)
    );

    rx_parity_chk #(.DW(DW)) u_par (
        .data (cap_data),
        .pbit (cap_pbit),
        .odd  (cap_odd),
        .perr (perr_calc)
    );

    rx_frame_core #(.DW(DW), .LW(LW), .REL(REL)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (sample_tick),
        .rx          (rx_s),
        .cfg_len     (cfg_len),
        .cfg_par_en  (cfg_par_en),
        .cfg_par_odd (cfg_par_odd),
        .perr_calc   (perr_calc),
        .cap_data    (cap_data),
        .cap_pbit    (cap_pbit),
        .cap_odd     (cap_odd),
        .valid_o     (rx_valid),
        .data_o      (rx_data),
        .perr_o      (rx_perr),
        .ferr_o      (rx_ferr),
        .brk_o       (rx_brk)
    );
endmodule

// File: tb/uart_rx_resync_tb.sv
`timescale 1ns/1ps
module uart_rx_resync_tb;
    localparam int TDIV = 4;          // clocks per sample tick
    localparam int BITC = 16 * TDIV;  // clocks per bit

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_tick = 1'b0;
    logic       rx_line = 1'b1;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       rx_valid;
    logic [7:0] rx_data;
    logic       rx_perr;
    logic       rx_ferr;
    logic       rx_brk;

    int checks = 0;
    int errors = 0;
    int cap_n = 0;
    logic [7:0] cap_d [0:31];
    logic       cap_p [0:31];
    logic       cap_f [0:31];
    logic       cap_b [0:31];

    uart_rx_resync u_dut (
        .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .rx_line(rx_line),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_perr(rx_perr),
        .rx_ferr(rx_ferr), .rx_brk(rx_brk)
    );

    always #2.5 clk = ~clk;

    // Sample enable generator.
    initial begin
        forever begin
            for (int i = 0; i < TDIV; i++) begin
                @(posedge clk);
                sample_tick <= (i == TDIV - 1);
            end
        end
    end

    // Record every strobed character, away from the active edge.
    always @(negedge clk) begin
        if (rx_valid && cap_n < 32) begin
            cap_d[cap_n] = rx_data;
            cap_p[cap_n] = rx_perr;
            cap_f[cap_n] = rx_ferr;
            cap_b[cap_n] = rx_brk;
            cap_n = cap_n + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic line_for(input logic v, input int clocks);
        rx_line = v;
        repeat (clocks) @(negedge clk);
    endtask

    task automatic send_char(input logic [7:0] d, input int nbits,
                             input bit pen, input logic pbit, input logic stopv);
        line_for(1'b0, BITC);
        for (int i = 0; i < nbits; i++) line_for(d[i], BITC);
        if (pen) line_for(pbit, BITC);
        line_for(stopv, BITC);
    endtask

    task automatic expect_char(input int idx, input string tag, input logic [7:0] d,
                               input logic p, input logic f, input logic b);
        chk(cap_d[idx] == d, {tag, " data"}, cap_d[idx], d);
        chk(cap_p[idx] == p, {tag, " perr"}, cap_p[idx], p);
        chk(cap_f[idx] == f, {tag, " ferr"}, cap_f[idx], f);
        chk(cap_b[idx] == b, {tag, " brk"}, cap_b[idx], b);
    endtask

    task automatic t_reset();
        chk(rx_valid == 1'b0, "R1 valid", rx_valid, 0);
        chk({rx_data, rx_perr, rx_ferr, rx_brk} == 11'd0, "R1 outputs",
            {rx_data, rx_perr, rx_ferr, rx_brk}, 0);
    endtask

    task automatic t_basic();
        int base = cap_n;
        cfg_len = 2'd3; cfg_par_en = 1'b0;
        send_char(8'hA5, 8, 1'b0, 1'b0, 1'b1);
        send_char(8'h3C, 8, 1'b0, 1'b0, 1'b1);
        line_for(1'b1, BITC);
        chk(cap_n - base == 2, "R3 strobe count", cap_n - base, 2);
        expect_char(base, "R3 first", 8'hA5, 0, 0, 0);
        expect_char(base + 1, "R3 second", 8'h3C, 0, 0, 0);
    endtask

    task automatic t_len5();
        int base = cap_n;
        cfg_len = 2'd0; cfg_par_en = 1'b0;
        send_char(8'hF6, 5, 1'b0, 1'b0, 1'b1);
        line_for(1'b1, BITC);
        chk(cap_n - base == 1, "R4 count", cap_n - base, 1);
        expect_char(base, "R4 five-bit", 8'h16, 0, 0, 0);
        cfg_len = 2'd3;
    endtask

    task automatic t_parity();
        int base = cap_n;
        cfg_len = 2'd3; cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
        send_char(8'h0B, 8, 1'b1, 1'b1, 1'b1);   // even, correct
        send_char(8'h0B, 8, 1'b1, 1'b0, 1'b1);   // even, wrong
        cfg_par_odd = 1'b1;
        send_char(8'h0B, 8, 1'b1, 1'b0, 1'b1);   // odd, correct
        line_for(1'b1, BITC);
        chk(cap_n - base == 3, "R5 count", cap_n - base, 3);
        expect_char(base, "R5 even ok", 8'h0B, 0, 0, 0);
        expect_char(base + 1, "R5 even bad", 8'h0B, 1, 0, 0);
        expect_char(base + 2, "R5 odd ok", 8'h0B, 0, 0, 0);
        cfg_par_en = 1'b0; cfg_par_odd = 1'b0;
    endtask

    task automatic t_glitch();
        int base = cap_n;
        line_for(1'b0, 3 * TDIV);
        line_for(1'b1, 3 * BITC);
        chk(cap_n == base, "R2 glitch ignored", cap_n - base, 0);
        send_char(8'h69, 8, 1'b0, 1'b0, 1'b1);
        line_for(1'b1, BITC);
        chk(cap_n - base == 1, "R2 after glitch count", cap_n - base, 1);
        expect_char(base, "R2 after glitch", 8'h69, 0, 0, 0);
    endtask

    task automatic t_zero();
        int base = cap_n;
        send_char(8'h00, 8, 1'b0, 1'b0, 1'b1);
        line_for(1'b1, BITC);
        chk(cap_n - base == 1, "R10 count", cap_n - base, 1);
        expect_char(base, "R10 zero char", 8'h00, 0, 0, 0);
    endtask

    task automatic t_resync();
        int base = cap_n;
        send_char(8'h55, 8, 1'b0, 1'b0, 1'b0);      // low stop
        for (int i = 0; i < 8; i++) line_for(((8'h3C >> i) & 1) != 0, BITC);
        line_for(1'b1, 2 * BITC);
        chk(cap_n - base == 2, "R7 count", cap_n - base, 2);
        expect_char(base, "R6 framing", 8'h55, 0, 1, 0);
        expect_char(base + 1, "R7 resync", 8'h3C, 0, 0, 0);
    endtask

    task automatic t_break();
        int base = cap_n;
        line_for(1'b0, 25 * BITC);
        chk(cap_n - base == 1, "R8 single break", cap_n - base, 1);
        expect_char(base, "R8 break", 8'h00, 0, 0, 1);
        line_for(1'b1, TDIV);                        // one high sample only
        line_for(1'b0, 15 * BITC);
        chk(cap_n - base == 1, "R9 still locked", cap_n - base, 1);
        line_for(1'b1, 3 * BITC);
        send_char(8'h5A, 8, 1'b0, 1'b0, 1'b1);
        line_for(1'b1, BITC);
        chk(cap_n - base == 2, "R9 release count", cap_n - base, 2);
        expect_char(base + 1, "R9 after release", 8'h5A, 0, 0, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        line_for(1'b1, BITC);
        t_basic();
        t_len5();
        t_parity();
        t_glitch();
        t_zero();
        t_resync();
        t_break();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule